// File: doc/BRIEF.md
# Write-Masked Split Register Port

This block is the register-file adapter of a pin-control bank. Each 32-bit control register is split across two word addresses: bits 15:0 sit at the register's base address and bits 31:16 at base + 4. Every write to one of these split halves carries its own bit enables. The upper 16 bits of the bus word select which of the 16 data bits in the lower half of the word are written. Software can therefore set or clear a single pin bit in one bus write, with no read-modify-write sequence and no lock around it.

The split registers hold the pin output levels, the pin directions and the interrupt configuration: enable, mask, trigger type, polarity and both-edge selection. They also hold the per-pin debounce enables and the debounce divider enables. Each logical register appears in full on an output port that feeds the pin and interrupt logic. That logic is outside this block.

A few registers are plain full-width words:
- the debounce divider control, which is read and write;
- the interrupt status, the raw status and the sampled pin levels, which are read-only views of inputs;
- a read-only version word.

The end-of-interrupt address takes masked writes and turns them into a one-cycle acknowledge pulse. Reads are combinational on the address. Writes take effect at the clock edge that samples them.

Top module: `split_regport`

## Requirements
- R1: After a synchronous active-low reset, every split register, the divider control word and the acknowledge pulse are zero. Every configuration output port therefore reads zero.
- R2: For a write to a split half, bus bits 15:0 are data and bus bits 31:16 are per-bit enables. A register bit takes its data bit only when its enable bit is 1. Bits whose enable is 0 keep their value. An enable of 1 with data 0 clears the bit, and an enable of 1 with data 1 sets it.
- R3: The split registers are placed on an 8-byte stride in this fixed order: output level 0x00, direction 0x08, interrupt enable 0x10, interrupt mask 0x18, trigger type 0x20, polarity 0x28, both-edge 0x30, debounce enable 0x38, divider enable 0x40. A write at base updates logical bits 15:0. A write at base + 4 updates logical bits 31:16. A write to one register changes no other register.
- R4: A read of a split half returns that half's 16 bits in bus bits 15:0, and zeros in bus bits 31:16.
- R5: The divider control word at 0x48 is written and read back as a full 32-bit word, with no masking.
- R6: Reads of 0x50, 0x58 and 0x70 return the interrupt status input, the raw status input and the pin level input. Writes to these addresses change no register.
- R7: A read of 0x78 returns the version word: the major number in bits 31:24, the minor number in bits 23:16 and the revision in bits 15:0. The defaults are major 0x02, minor 0x05 and revision 0x1A3C, giving 0x02051A3C.
- R8: Reads of unmapped addresses return zero, and writes to them change no register. Unmapped addresses include 0x4C, 0x68, 0x7C and any address with bits 1:0 not zero.
- R9: A write to 0x60 or 0x64 pulses the acknowledge output for exactly the cycle after the write. The pulse carries enable AND data of the write: in bits 15:0 for 0x60 and in bits 31:16 for 0x64. Both addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write word (split halves: enables 31:16, data 15:0) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_status_in | input | 32 | Masked interrupt status from the interrupt logic |
| irq_raw_in | input | 32 | Raw interrupt status from the interrupt logic |
| pin_level_in | input | 32 | Sampled pin levels |
| out_level | output | 32 | Pin output levels |
| pin_dir | output | 32 | Pin directions, 1 = output, 0 = input |
| irq_en | output | 32 | Interrupt enables |
| irq_mask | output | 32 | Interrupt masks |
| irq_type | output | 32 | Trigger type per pin |
| irq_pol | output | 32 | Trigger polarity per pin |
| irq_both | output | 32 | Both-edge trigger select per pin |
| db_en | output | 32 | Debounce enables |
| dbdiv_en | output | 32 | Debounce divider enables |
| dbdiv_ctl | output | 32 | Debounce divider control word |
| ack_pulse | output | 32 | One-cycle end-of-interrupt acknowledge bits |

## Verification
The bench exercises the bit enables in two ways:
- A write that clears one bit while setting another shows whether the enables are honoured. A design that treated the word as plain data would wipe the neighbouring bits.
- A write whose enables are all zero shows whether unenabled bits hold. A design that ignored the enables would change the register.

An upper-half write checks that bits land in 31:16, which a design ignoring address bit 2 would corrupt. Distinct values are then written to every split register and each one is read back. That catches decoders that alias neighbouring slots or swap the order of the registers.

Writes to the read-only, unmapped and misaligned addresses must leave every register unchanged, which a decoder that drops address bits would violate. The acknowledge pulse is checked in both halves and for its single-cycle width; a level-held or misplaced pulse would fail.

// File: rtl/regport_pkg.sv
// Package: shared slot numbers of the split register port.
// Each slot is an 8-byte pair of word addresses; slot = byte address bits 7:3.
package regport_pkg;
    localparam int NMASK       = 9;   // split, write-masked slots 0..8
    localparam int SLOT_DIVCTL = 9;
    localparam int SLOT_STAT   = 10;
    localparam int SLOT_RAW    = 11;
    localparam int SLOT_ACK    = 12;
    localparam int SLOT_EXT    = 14;
    localparam int SLOT_VER    = 15;
endpackage

// File: rtl/wm_half_reg.sv
// Module: one 16-bit half of a split register.
// Assumes the write word carries enables in its upper half and data in its lower half.
module wm_half_reg #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [2*HW-1:0] wdata,
    output logic [HW-1:0]   q
);
    logic [HW-1:0] en;
    logic [HW-1:0] d;

    assign en = wdata[2*HW-1:HW];
    assign d  = wdata[HW-1:0];

    // Update only the enabled bits; hold the rest.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= (q & ~en) | (d & en);
    end
endmodule

// File: rtl/regport_rdmux.sv
// Module: combinational read multiplexer of the split register port.
// Assumes word-aligned accesses; anything else, and any unmapped slot, reads zero.
module regport_rdmux
    import regport_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 5
) (
    input  logic                      aligned,
    input  logic                      hi,
    input  logic [SW-1:0]             slot,
    input  logic [NMASK-1:0][DW-1:0]  cfg_q,
    input  logic [DW-1:0]             divctl,
    input  logic [DW-1:0]             status,
    input  logic [DW-1:0]             raw,
    input  logic [DW-1:0]             pins,
    input  logic [DW-1:0]             version,
    output logic [DW-1:0]             rdata
);
    localparam int HW = DW / 2;

    // Select the read word from the slot and half.
    always_comb begin
        rdata = '0;
        if (aligned) begin
            for (int i = 0; i < NMASK; i++) begin
                if (slot == SW'(i))
                    rdata = {{HW{1'b0}}, hi ? cfg_q[i][DW-1:HW] : cfg_q[i][HW-1:0]};
            end
            if (!hi) begin
                case (slot)
                    SW'(SLOT_DIVCTL): rdata = divctl;
                    SW'(SLOT_STAT):   rdata = status;
                    SW'(SLOT_RAW):    rdata = raw;
                    SW'(SLOT_EXT):    rdata = pins;
                    SW'(SLOT_VER):    rdata = version;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/split_regport.sv
// Module: write-masked split register port of a pin-control bank.
// Every 32-bit configuration register spans two word addresses (low half at base,
// high half at base+4); writes to a half carry per-bit enables in the upper bus half.
// Assumes single-cycle writes, combinational reads and a synchronous active-low reset.
module split_regport
    import regport_pkg::*;
#(
    parameter int           DW        = 32,
    parameter int           AW        = 8,
    parameter logic [7:0]   VER_MAJOR = 8'h02,
    parameter logic [7:0]   VER_MINOR = 8'h05,
    parameter logic [15:0]  VER_REV   = 16'h1A3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] irq_status_in,
    input  logic [DW-1:0] irq_raw_in,
    input  logic [DW-1:0] pin_level_in,
    output logic [DW-1:0] out_level,
    output logic [DW-1:0] pin_dir,
    output logic [DW-1:0] irq_en,
    output logic [DW-1:0] irq_mask,
    output logic [DW-1:0] irq_type,
    output logic [DW-1:0] irq_pol,
    output logic [DW-1:0] irq_both,
    output logic [DW-1:0] db_en,
    output logic [DW-1:0] dbdiv_en,
    output logic [DW-1:0] dbdiv_ctl,
    output logic [DW-1:0] ack_pulse
);
    localparam int HW = DW / 2;
    localparam int SW = AW - 3;
    localparam logic [DW-1:0] VER_WORD = DW'({VER_MAJOR, VER_MINOR, VER_REV});

    logic                     aligned;
    logic                     hi;
    logic [SW-1:0]            slot;
    logic [NMASK-1:0][DW-1:0] cfg_q;
    logic [HW-1:0]            ack_bits;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign hi       = bus_addr[2];
    assign slot     = bus_addr[AW-1:3];
    assign ack_bits = bus_wdata[HW-1:0] & bus_wdata[DW-1:HW];

    // One masked half register per slot and half.
    for (genvar i = 0; i < NMASK; i++) begin : g_slot
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic we;
            assign we = bus_wr && aligned && (slot == SW'(i)) && (hi == (h != 0));
            wm_half_reg #(.HW(HW)) u_half (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we),
                .wdata (bus_wdata),
                .q     (cfg_q[i][h*HW +: HW])
            );
        end
    end

    // Full-width divider control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbdiv_ctl <= '0;
        else if (bus_wr && aligned && !hi && slot == SW'(SLOT_DIVCTL))
            dbdiv_ctl <= bus_wdata;
    end

    // One-cycle acknowledge pulse from masked writes to the end-of-interrupt pair.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_pulse <= '0;
        else if (bus_wr && aligned && slot == SW'(SLOT_ACK))
            ack_pulse <= hi ? {ack_bits, {HW{1'b0}}} : {{HW{1'b0}}, ack_bits};
        else
            ack_pulse <= '0;
    end

    assign out_level = cfg_q[0];
    assign pin_dir   = cfg_q[1];
    assign irq_en    = cfg_q[2];
    assign irq_mask  = cfg_q[3];
    assign irq_type  = cfg_q[4];
    assign irq_pol   = cfg_q[5];
    assign irq_both  = cfg_q[6];
    assign db_en     = cfg_q[7];
    assign dbdiv_en  = cfg_q[8];

    regport_rdmux #(.DW(DW), .SW(SW)) u_rdmux (
        .aligned (aligned),
        .hi      (hi),
        .slot    (slot),
        .cfg_q   (cfg_q),
        .divctl  (dbdiv_ctl),
        .status  (irq_status_in),
        .raw     (irq_raw_in),
        .pins    (pin_level_in),
        .version (VER_WORD),
        .rdata   (bus_rdata)
    );
endmodule

// Checker: timing properties of the split register port.
module split_regport_checker #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] out_level,
    input logic [DW-1:0] ack_pulse
);
    localparam int HW = DW / 2;

    // R2: without a write to the low output-level half, its bits hold.
    a_r2_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == AW'(0)) |=> $stable(out_level[HW-1:0]));

    // R2: a masked write changes only enabled bits.
    a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(0)) |=>
        (((out_level[HW-1:0] ^ $past(out_level[HW-1:0])) & ~$past(bus_wdata[DW-1:HW])) == '0));

    // R4: split halves read with a zero upper half.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < AW'(8'h48)) |-> (bus_rdata[DW-1:HW] == '0));

    // R8: an unmapped address reads zero.
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(8'h4C) || bus_addr == AW'(8'h7C) || bus_addr[1:0] != 2'b00)
        |-> (bus_rdata == '0));

    // R9: without a write there is no acknowledge pulse next cycle.
    a_r9_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (ack_pulse == '0));
endmodule

bind split_regport split_regport_checker #(.DW(DW), .AW(AW)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .out_level (out_level),
    .ack_pulse (ack_pulse)
);

// File: tb/split_regport_bench.sv
`timescale 1ns/1ps
// Directed bench for the split register port; one task per scenario.
module split_regport_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_status_in = '0, irq_raw_in = '0, pin_level_in = '0;
    logic [31:0] out_level, pin_dir, irq_en, irq_mask, irq_type, irq_pol;
    logic [31:0] irq_both, db_en, dbdiv_en, dbdiv_ctl, ack_pulse;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [9];
    logic [31:0] div_model = '0;

    always #4 clk = ~clk;

    split_regport u_split_regport (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_status_in(irq_status_in), .irq_raw_in(irq_raw_in),
        .pin_level_in(pin_level_in), .out_level(out_level), .pin_dir(pin_dir),
        .irq_en(irq_en), .irq_mask(irq_mask), .irq_type(irq_type),
        .irq_pol(irq_pol), .irq_both(irq_both), .db_en(db_en),
        .dbdiv_en(dbdiv_en), .dbdiv_ctl(dbdiv_ctl), .ack_pulse(ack_pulse)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] port_of(int i);
        case (i)
            0: return out_level;  1: return pin_dir;   2: return irq_en;
            3: return irq_mask;   4: return irq_type;  5: return irq_pol;
            6: return irq_both;   7: return db_en;     default: return dbdiv_en;
        endcase
    endfunction

    // Drive one write cycle; the register updates at the posedge in between.
    task automatic bus_write(logic [7:0] a, logic [31:0] w);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Model of a masked write to split slot s, half h.
    task automatic model_write(int s, int h, logic [31:0] w);
        logic [15:0] cur;
        cur = h ? model[s][31:16] : model[s][15:0];
        cur = (cur & ~w[31:16]) | (w[15:0] & w[31:16]);
        if (h) model[s][31:16] = cur; else model[s][15:0] = cur;
    endtask

    task automatic read_check(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic check_all_regs(string req);
        for (int i = 0; i < 9; i++) begin
            check(req, port_of(i), model[i]);
            read_check(req, 8'(i * 8), {16'h0, model[i][15:0]});
            read_check(req, 8'(i * 8 + 4), {16'h0, model[i][31:16]});
        end
        check(req, dbdiv_ctl, div_model);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 9; i++) check("R1", port_of(i), 32'h0);
        check("R1", dbdiv_ctl, 32'h0);
        check("R1", ack_pulse, 32'h0);
        read_check("R1", 8'h00, 32'h0);
    endtask

    task automatic t_masked_bits;
        bus_write(8'h00, 32'h00FF_00FF); model_write(0, 0, 32'h00FF_00FF);
        check("R2", out_level, 32'h0000_00FF);
        bus_write(8'h00, 32'h0081_0001); model_write(0, 0, 32'h0081_0001);
        check("R2", out_level, 32'h0000_007F);
        bus_write(8'h00, 32'h0000_FFFF); model_write(0, 0, 32'h0000_FFFF);
        check("R2", out_level, 32'h0000_007F);
        read_check("R4", 8'h00, 32'h0000_007F);
    endtask

    task automatic t_upper_half;
        bus_write(8'h04, 32'hF000_A5A5); model_write(0, 1, 32'hF000_A5A5);
        check("R3", out_level, 32'hA000_007F);
        read_check("R4", 8'h04, 32'h0000_A000);
        bus_write(8'h0C, 32'hFFFF_1234); model_write(1, 1, 32'hFFFF_1234);
        check("R3", pin_dir, 32'h1234_0000);
        check("R3", irq_en, 32'h0);
    endtask

    task automatic t_every_slot;
        for (int i = 0; i < 9; i++) begin
            logic [31:0] w;
            w = {16'hFFFF, 16'(16'h1111 * (i + 1))};
            bus_write(8'(i * 8), w);
            model_write(i, 0, w);
        end
        check_all_regs("R3");
    endtask

    task automatic t_full_word;
        bus_write(8'h48, 32'hDEAD_BEEF); div_model = 32'hDEAD_BEEF;
        check("R5", dbdiv_ctl, 32'hDEAD_BEEF);
        read_check("R5", 8'h48, 32'hDEAD_BEEF);
    endtask

    task automatic t_read_only;
        irq_status_in = 32'h1357_2468; irq_raw_in = 32'hCAFE_F00D; pin_level_in = 32'h8000_0001;
        read_check("R6", 8'h50, 32'h1357_2468);
        read_check("R6", 8'h58, 32'hCAFE_F00D);
        read_check("R6", 8'h70, 32'h8000_0001);
        bus_write(8'h50, 32'hFFFF_FFFF);
        bus_write(8'h58, 32'hFFFF_FFFF);
        bus_write(8'h70, 32'hFFFF_FFFF);
        bus_write(8'h78, 32'hFFFF_FFFF);
        read_check("R6", 8'h50, 32'h1357_2468);
        check_all_regs("R6");
    endtask

    task automatic t_version;
        read_check("R7", 8'h78, 32'h0205_1A3C);
    endtask

    task automatic t_unmapped;
        read_check("R8", 8'h4C, 32'h0);
        read_check("R8", 8'h68, 32'h0);
        read_check("R8", 8'h7C, 32'h0);
        read_check("R8", 8'h01, 32'h0);
        bus_write(8'h4C, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'hFFFF_FFFF);
        bus_write(8'h06, 32'hFFFF_FFFF);
        bus_write(8'h6C, 32'hFFFF_FFFF);
        check_all_regs("R8");
    endtask

    task automatic t_ack;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h60; bus_wdata = 32'h00F0_0030;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9", ack_pulse, 32'h0000_0030);
        @(negedge clk);
        check("R9", ack_pulse, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h64; bus_wdata = 32'h8000_FFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9", ack_pulse, 32'h8000_0000);
        @(negedge clk);
        check("R9", ack_pulse, 32'h0);
        read_check("R9", 8'h60, 32'h0);
        read_check("R9", 8'h64, 32'h0);
        check_all_regs("R9");
    endtask

    initial begin
        for (int i = 0; i < 9; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked_bits();
        t_upper_half();
        t_every_slot();
        t_full_word();
        t_read_only();
        t_version();
        t_unmapped();
        t_ack();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule